// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer/Counter

This block is a 16-bit timer/counter placed behind an 8-bit register bus. Software reaches the count, and the last capture timestamp, one byte at a time. A single shared high-byte holding register keeps each 16-bit transfer atomic:

- Reading a low byte freezes the matching high byte in the holding register.
- Writing a high byte only stages it in the holding register.
- Writing the low byte commits all sixteen bits in one clock.

The count advances on a tick chosen by a 3-bit clock-select field. The tick can come from a free-running prescaler or from an edge of a synchronised external clock. In plain up mode the count wraps at its maximum. In up/down mode it turns around at both ends. An overflow flag marks the wrap, or the arrival at zero. An input capture path timestamps a chosen edge of one of two event inputs and raises a capture flag. Both flags are cleared by writing ones to them.

Top module: `tmr16_bytebus`

## Requirements
- R1: After reset the count, the capture value, the control byte (address 0) and the flag byte (address 1) all read 0. bottom_o is 1 and top_o is 0.
- R2: A read of address 2 returns the count's low byte and, in the same cycle, copies the count's high byte into the holding register. A following read of address 3 returns that holding register, so the pair is consistent even when a carry occurs between the two reads.
- R3: A write to address 3 changes only the holding register and leaves the count unchanged. A write to address 2 loads the count with {holding register, written byte} in one cycle.
- R4: A count write takes priority over a tick in the same cycle: the next cycle shows exactly the written value, even while the counter runs at full rate.
- R5: Control bits [2:0] select the tick source. 0 stops the counter. 1, 2, 3, 4 and 5 tick once every 1, 8, 64, 256 and 1024 clocks. 6 and 7 tick on a falling or rising edge of ext_clk_i, after a two-flop synchroniser.
- R6: With control bit 3 at 0 the count increments on each tick and wraps from 0xFFFF to 0; the wrap sets flag bit 0.
- R7: With control bit 3 at 1 the count rises to 0xFFFF, then falls to 0, then rises again. Flag bit 0 sets when the falling count reaches 0 and does not set at 0xFFFF.
- R8: top_o is 1 exactly when the count is 0xFFFF; bottom_o is 1 exactly when the count is 0.
- R9: Writing a 1 to a flag bit clears it; writing 0 leaves it set.
- R10: Control bit 4 selects the capture source (0 = cap_pin_i, 1 = cap_cmp_i) and control bit 5 the edge (1 = rising, 0 = falling). Only the selected edge of the selected source, after a two-flop synchroniser, copies the count into the capture register and sets flag bit 1. Activity on the other source has no effect.
- R11: The capture value reads through addresses 4 (low byte) and 5 (high byte) with the same holding-register scheme: a read of 4 copies the capture high byte for the following read of 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (updates the holding register) |
| rdata_o | output | 8 | Read data for addr_i |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| cap_pin_i | input | 1 | Capture event from a pin, asynchronous |
| cap_cmp_i | input | 1 | Capture event from a comparator, asynchronous |
| top_o | output | 1 | Count is at its maximum |
| bottom_o | output | 1 | Count is zero |
| ovf_flag_o | output | 1 | Overflow flag |
| cap_flag_o | output | 1 | Capture flag |

## Verification
The collision that matters is a bus access to the count in the same clock as a tick. The bench runs the counter at the full clock rate and issues a high-byte stage and a low-byte commit back to back. It then reads the low byte in the very next cycle and expects the written value exactly, with no increment folded in. A second collision pairs a low-byte read with the tick that carries into the high byte. The bench commits 0x12FF and reads low then high while the count has already moved to 0x1300. The pair must still be 0xFF and 0x12, which shows that the holding register, not the live high byte, answered the second read.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int ADDR_W  = 3;
    localparam int PRESC_W = 10;

    localparam int FLG_OVF = 0;
    localparam int FLG_CAP = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_FLAGS  = 3'd1,
        A_CNT_LO = 3'd2,
        A_CNT_HI = 3'd3,
        A_CAP_LO = 3'd4,
        A_CAP_HI = 3'd5
    } reg_addr_e;

    typedef enum logic [2:0] {
        CS_OFF      = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic     cap_rise;
        logic     cap_src_cmp;
        logic     updown;
        clk_sel_e cs;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Log2 of the prescale ratio for each prescaled code.
    function automatic int presc_shift(clk_sel_e cs);
        case (cs)
            CS_DIV8:    return 3;
            CS_DIV64:   return 6;
            CS_DIV256:  return 8;
            CS_DIV1024: return 10;
            default:    return 0;
        endcase
    endfunction

    // Low bits of the prescaler that must all be 1 for a tick.
    function automatic logic [PRESC_W-1:0] presc_mask(clk_sel_e cs);
        logic [PRESC_W-1:0] one;
        one = PRESC_W'(1);
        return (one << presc_shift(cs)) - one;
    endfunction

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic rise_o,
    output logic fall_o
);

    // sh_q[0..STAGES-1] synchronise, sh_q[STAGES] holds the previous value.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], d_i};
        end
    end

    assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e cs_i,
    input  logic     ext_i,
    output logic     tick_o
);

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] mask;
    logic               ext_rise;
    logic               ext_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    tmr16_edge #(.STAGES(SYNC_STAGES)) u_ext_edge (
        .clk    (clk),
        .rst    (rst),
        .d_i    (ext_i),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    always_comb begin
        mask = presc_mask(cs_i);
        case (cs_i)
            CS_OFF:      tick_o = 1'b0;
            CS_EXT_FALL: tick_o = ext_fall;
            CS_EXT_RISE: tick_o = ext_rise;
            default:     tick_o = ((presc_q & mask) == mask);
        endcase
    end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         updown_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_evt_o,
    output logic         at_top_o,
    output logic         at_bottom_o
);

    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q;
    logic         down_q;
    logic         step_down;
    logic [W-1:0] cnt_nxt;

    assign at_top_o    = (cnt_q == MAXV);
    assign at_bottom_o = (cnt_q == '0);

    // Direction for this tick: forced at the ends, otherwise remembered.
    always_comb begin
        if (!updown_i) begin
            step_down = 1'b0;
        end else if (at_top_o) begin
            step_down = 1'b1;
        end else if (at_bottom_o) begin
            step_down = 1'b0;
        end else begin
            step_down = down_q;
        end
        cnt_nxt = step_down ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= load_val_i;
        end else if (tick_i) begin
            cnt_q  <= cnt_nxt;
            down_q <= step_down;
        end
    end

    // A load swallows the tick, so no flag event either.
    assign ovf_evt_o = tick_i && !load_i &&
                       (updown_i ? (cnt_nxt == '0) : at_top_o);

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic             cmp_i,
    input  logic             src_cmp_i,
    input  logic             rise_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             evt_o
);

    logic             src;
    logic             s_rise;
    logic             s_fall;
    logic [CNT_W-1:0] cap_q;

    assign src = src_cmp_i ? cmp_i : pin_i;

    tmr16_edge #(.STAGES(SYNC_STAGES)) u_cap_edge (
        .clk    (clk),
        .rst    (rst),
        .d_i    (src),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    assign evt_o = rise_sel_i ? s_rise : s_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (evt_o) begin
            cap_q <= cnt_i;
        end
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/tmr16_bytebus.sv
module tmr16_bytebus
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic              ext_clk_i,
    input  logic              cap_pin_i,
    input  logic              cap_cmp_i,
    output logic              top_o,
    output logic              bottom_o,
    output logic              ovf_flag_o,
    output logic              cap_flag_o
);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] temp_q;
    logic              ovf_q;
    logic              capf_q;

    logic              tick_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  cap_w;
    logic              ovf_evt;
    logic              cap_evt;

    reg_addr_e         a;
    logic              wr_ctrl, wr_flags, wr_cnt_lo, wr_cnt_hi;
    logic              rd_cnt_lo, rd_cap_lo;

    assign a         = reg_addr_e'(addr_i);
    assign wr_ctrl   = wr_i && (a == A_CTRL);
    assign wr_flags  = wr_i && (a == A_FLAGS);
    assign wr_cnt_lo = wr_i && (a == A_CNT_LO);
    assign wr_cnt_hi = wr_i && (a == A_CNT_HI);
    assign rd_cnt_lo = rd_i && (a == A_CNT_LO);
    assign rd_cap_lo = rd_i && (a == A_CAP_LO);

    tmr16_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .cs_i   (ctrl_q.cs),
        .ext_i  (ext_clk_i),
        .tick_o (tick_w)
    );

    tmr16_core #(.W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_w),
        .updown_i    (ctrl_q.updown),
        .load_i      (wr_cnt_lo),
        .load_val_i  ({temp_q, wdata_i}),
        .cnt_o       (cnt_w),
        .ovf_evt_o   (ovf_evt),
        .at_top_o    (top_o),
        .at_bottom_o (bottom_o)
    );

    tmr16_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (cap_pin_i),
        .cmp_i      (cap_cmp_i),
        .src_cmp_i  (ctrl_q.cap_src_cmp),
        .rise_sel_i (ctrl_q.cap_rise),
        .cnt_i      (cnt_w),
        .cap_o      (cap_w),
        .evt_o      (cap_evt)
    );

    // Control register
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    // Shared high-byte holding register: write staging beats read latching.
    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
        end else if (wr_cnt_hi) begin
            temp_q <= wdata_i;
        end else if (!wr_i && rd_cnt_lo) begin
            temp_q <= cnt_w[CNT_W-1:BYTE_W];
        end else if (!wr_i && rd_cap_lo) begin
            temp_q <= cap_w[CNT_W-1:BYTE_W];
        end
    end

    // Flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q  <= 1'b0;
            capf_q <= 1'b0;
        end else begin
            ovf_q  <= ovf_evt | (ovf_q  & ~(wr_flags & wdata_i[FLG_OVF]));
            capf_q <= cap_evt | (capf_q & ~(wr_flags & wdata_i[FLG_CAP]));
        end
    end

    assign ovf_flag_o = ovf_q;
    assign cap_flag_o = capf_q;

    always_comb begin
        rdata_o = '0;
        case (a)
            A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
            A_FLAGS: begin
                rdata_o[FLG_OVF] = ovf_q;
                rdata_o[FLG_CAP] = capf_q;
            end
            A_CNT_LO: rdata_o = cnt_w[BYTE_W-1:0];
            A_CNT_HI: rdata_o = temp_q;
            A_CAP_LO: rdata_o = cap_w[BYTE_W-1:0];
            A_CAP_HI: rdata_o = temp_q;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tmr16_bytebus_chk.sv
module tmr16_bytebus_chk
    import tmr16_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BYTE_W-1:0] wdata_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cap,
    input logic [BYTE_W-1:0] temp,
    input logic              tick,
    input ctrl_t             ctrl,
    input logic              ovf,
    input logic              capf
);

    logic cnt_wr;
    assign cnt_wr = wr_i && (addr_i == A_CNT_LO);

    // R2: a low-byte read freezes the high byte of that same cycle
    assert_lo_read_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !wr_i && addr_i == A_CNT_LO) |=> temp == $past(cnt[CNT_W-1:BYTE_W]));

    // R3 / R4: the commit uses the staged byte and beats any tick
    assert_lo_write_commit_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt == {$past(temp), $past(wdata_i)});

    // R5: stopped counter holds unless written
    assert_stop_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cs == CS_OFF && !cnt_wr) |=> $stable(cnt));

    // R6: plain up-count step
    assert_up_step_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl.updown && !cnt_wr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R7: the overflow flag only rises together with a count of zero
    assert_ovf_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> cnt == '0);

    // R10: a fresh capture holds the count of the event cycle
    assert_capture_value_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(capf) |-> cap == $past(cnt));

endmodule

bind tmr16_bytebus tmr16_bytebus_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .cnt     (cnt_w),
    .cap     (cap_w),
    .temp    (temp_q),
    .tick    (tick_w),
    .ctrl    (ctrl_q),
    .ovf     (ovf_q),
    .capf    (capf_q)
);

// File: tb/tmr16_bytebus_test.sv
`timescale 1ns/1ps
module tmr16_bytebus_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wr_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] rdata_o;
    logic       ext_clk_i = 1'b0;
    logic       cap_pin_i = 1'b0;
    logic       cap_cmp_i = 1'b0;
    logic       top_o, bottom_o, ovf_flag_o, cap_flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] last_rd;

    typedef struct {
        logic [7:0] exp;
        string      req;
        bit         chk;
    } sb_item_t;
    sb_item_t sbq[$];

    always #4 clk = ~clk;

    tmr16_bytebus uut (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .rdata_o    (rdata_o),
        .ext_clk_i  (ext_clk_i),
        .cap_pin_i  (cap_pin_i),
        .cap_cmp_i  (cap_cmp_i),
        .top_o      (top_o),
        .bottom_o   (bottom_o),
        .ovf_flag_o (ovf_flag_o),
        .cap_flag_o (cap_flag_o)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Driver: one bus operation per cycle, driven at the falling edge.
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_i = 1'b0; rd_i = 1'b0;
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    endtask

    task automatic rd_exp(logic [2:0] a, logic [7:0] e, string req);
        sb_item_t it;
        @(negedge clk);
        addr_i = a; wr_i = 1'b0; rd_i = 1'b1;
        it.exp = e; it.req = req; it.chk = 1'b1;
        sbq.push_back(it);
    endtask

    task automatic rd_raw(logic [2:0] a, output logic [7:0] v);
        sb_item_t it;
        @(negedge clk);
        addr_i = a; wr_i = 1'b0; rd_i = 1'b1;
        it.exp = '0; it.req = ""; it.chk = 1'b0;
        sbq.push_back(it);
        #3.5;
        v = last_rd;
    endtask

    task automatic port_chk(string req, logic t, logic b);
        @(negedge clk);
        wr_i = 1'b0; rd_i = 1'b0;
        #3;
        check({req, " top_o"}, 16'(top_o), 16'(t));
        check({req, " bottom_o"}, 16'(bottom_o), 16'(b));
    endtask

    // Monitor: pops an expectation for every read it sees.
    always begin
        @(negedge clk);
        #3;
        if (rd_i) begin
            if (sbq.size() == 0) begin
                check("SB unexpected read", 16'(rdata_o), 16'hxxxx);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                last_rd = rdata_o;
                if (it.chk) check(it.req, 16'(rdata_o), 16'(it.exp));
            end
        end
    end

    task automatic presc_win(logic [7:0] cs, int win, int exp_ticks, string req);
        logic [7:0] v0, v1;
        wr(3'd0, cs);
        rd_raw(3'd2, v0);
        idle(win - 1);
        rd_raw(3'd2, v1);
        check(req, 16'(v1 - v0), 16'(exp_ticks));
        wr(3'd0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_exp(3'd0, 8'h00, "R1 ctrl");
        rd_exp(3'd1, 8'h00, "R1 flags");
        rd_exp(3'd2, 8'h00, "R1 cnt lo");
        rd_exp(3'd4, 8'h00, "R1 cap lo");
        port_chk("R1", 1'b0, 1'b1);

        // R4 exact landing while counting every clock
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h12);
        wr(3'd2, 8'h34);
        rd_exp(3'd2, 8'h34, "R4 lo after write");
        rd_exp(3'd3, 8'h12, "R4 hi after write");
        // R2 carry between the two reads: 0x12FF then 0x1300
        wr(3'd3, 8'h12);
        wr(3'd2, 8'hFF);
        rd_exp(3'd2, 8'hFF, "R2 lo before carry");
        rd_exp(3'd3, 8'h12, "R2 hi held across carry");
        wr(3'd0, 8'h00);  // last tick lands here: count 0x1302
        // R5 stopped, R3 staging does not move the count
        idle(10);
        rd_exp(3'd2, 8'h02, "R5 stopped lo");
        rd_exp(3'd3, 8'h13, "R5 stopped hi");
        wr(3'd3, 8'h55);
        rd_exp(3'd2, 8'h02, "R3 lo untouched by hi write");
        rd_exp(3'd3, 8'h13, "R3 hi untouched by hi write");
        wr(3'd3, 8'h55);
        wr(3'd2, 8'h66);
        rd_exp(3'd2, 8'h66, "R3 commit lo");
        rd_exp(3'd3, 8'h55, "R3 commit hi");

        // R5 prescaled rates over exact windows
        presc_win(8'h02, 64,   8, "R5 div8");
        presc_win(8'h03, 128,  2, "R5 div64");
        presc_win(8'h04, 512,  2, "R5 div256");
        presc_win(8'h05, 2048, 2, "R5 div1024");

        // R5 external rising edges
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h07);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_clk_i = 1'b1; wr_i = 1'b0; rd_i = 1'b0;
            idle(3);
            @(negedge clk); ext_clk_i = 1'b0;
            idle(3);
        end
        idle(5);
        rd_exp(3'd2, 8'h05, "R5 external rise count");
        wr(3'd0, 8'h00);

        // R7 up/down: FFFD -> FFFE -> FFFF
        wr(3'd0, 8'h08);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFD);
        wr(3'd0, 8'h09);
        idle(1);
        wr(3'd0, 8'h08);
        port_chk("R8 at max", 1'b1, 1'b0);
        rd_exp(3'd2, 8'hFF, "R7 reached max lo");
        rd_exp(3'd1, 8'h00, "R7 no flag at max");
        // turn: FFFE, FFFD
        wr(3'd0, 8'h09);
        idle(1);
        wr(3'd0, 8'h08);
        rd_exp(3'd2, 8'hFD, "R7 falling after max");
        rd_exp(3'd3, 8'hFF, "R7 falling hi");
        // 0002 -> 0001 -> 0000
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h02);
        wr(3'd0, 8'h09);
        idle(1);
        wr(3'd0, 8'h08);
        port_chk("R8 at zero", 1'b0, 1'b1);
        rd_exp(3'd1, 8'h01, "R7 flag at bottom");
        wr(3'd0, 8'h09);
        wr(3'd0, 8'h08);
        rd_exp(3'd2, 8'h01, "R7 rising after bottom");

        // R9 flag clear
        wr(3'd1, 8'h00);
        rd_exp(3'd1, 8'h01, "R9 write 0 keeps flag");
        wr(3'd1, 8'h01);
        rd_exp(3'd1, 8'h00, "R9 write 1 clears flag");

        // R6 up mode wrap FFFE -> FFFF -> 0000
        wr(3'd0, 8'h00);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFE);
        wr(3'd0, 8'h01);
        idle(1);
        wr(3'd0, 8'h00);
        rd_exp(3'd2, 8'h00, "R6 wrap lo");
        rd_exp(3'd3, 8'h00, "R6 wrap hi");
        rd_exp(3'd1, 8'h01, "R6 wrap flag");
        wr(3'd1, 8'h01);

        // R10 capture: pin source, rising edge; comparator activity ignored
        wr(3'd3, 8'h43);
        wr(3'd2, 8'h21);
        wr(3'd0, 8'h20);
        @(negedge clk); cap_cmp_i = 1'b1; wr_i = 1'b0; rd_i = 1'b0;
        idle(5);
        rd_exp(3'd1, 8'h00, "R10 other source ignored flag");
        rd_exp(3'd4, 8'h00, "R10 other source ignored value");
        @(negedge clk); cap_pin_i = 1'b1; wr_i = 1'b0; rd_i = 1'b0;
        idle(5);
        rd_exp(3'd1, 8'h02, "R10 pin rise flag");
        rd_exp(3'd4, 8'h21, "R11 capture lo");
        rd_exp(3'd5, 8'h43, "R11 capture hi");
        // comparator source, falling edge
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'hAB);
        wr(3'd0, 8'h10);
        rd_exp(3'd1, 8'h00, "R9 capture flag cleared");
        @(negedge clk); cap_cmp_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
        idle(5);
        rd_exp(3'd1, 8'h02, "R10 comparator fall flag");
        rd_exp(3'd4, 8'hAB, "R11 capture lo falling");
        rd_exp(3'd5, 8'h00, "R11 capture hi falling");

        idle(3);
        if (sbq.size() != 0) check("SB pending reads", 16'(sbq.size()), 16'd0);
        report();
    end

endmodule